// File: doc/BRIEF.md
# Stack Push/Pop Access Generator

This block converts one stack request into a new stack-pointer value and a single memory access described by an address, a byte-lane mask and write data. There are three kinds of request: push a segment selector, pop a segment selector, and push an exception error code. A per-request mode bit chooses between two legacy width behaviours. In narrow mode the stored or loaded value is always two bytes, while the stack pointer still moves by the full operand size. In wide mode the access width follows the operand size, and any upper bytes are written as zeros.

The stack segment can be 16-bit or 32-bit. On a 16-bit segment only the low half of the pointer moves and wraps, and the upper half is kept as it was. Before any access is issued, every byte it would touch is compared with the segment limit. A request that would reach past the limit reports a fault, issues no access and leaves the pointer unchanged. Requests are taken on a valid/ready handshake, and the registered result appears on the next cycle together with a one-cycle done pulse.

Top module: `stk_access_gen`

## Requirements
- R1: A selector push (req_kind 2'b00) lowers the stack pointer by the operand size (4 when req_op32=1, else 2), and the write goes to the lowered pointer value.
- R2: In narrow mode (req_wide=0) every selector push, selector pop and error-code push uses byte enables 4'b0011 only, even when the operand size is 4.
- R3: In wide mode (req_wide=1) the byte enables of a selector access cover the operand size (4'b1111 for 4 bytes, 4'b0011 for 2). Write data always holds the value in lanes 0–1 and zeros in lanes 2–3.
- R4: A selector pop (req_kind 2'b01) reads at the current pointer with acc_write=0 and raises the pointer by the operand size.
- R5: An error-code push (req_kind 2'b10) lowers the pointer by the operand size. It writes 2 bytes in narrow mode and 4 bytes in wide mode, with the upper 16 bits zero.
- R6: On a 16-bit stack segment (req_stk32=0) only bits 15:0 of the pointer change and wrap modulo 65536, bits 31:16 are preserved, and the access address is the 16-bit offset zero-extended. A pop at 0xFFFC (4-byte) or 0xFFFE (2-byte) yields low pointer bits 0x0000.
- R7: fault is raised when the offset of the last byte accessed (address + bytes − 1) is greater than req_limit. Because narrow mode touches only 2 bytes, a 4-byte request can fault in wide mode and not in narrow mode.
- R8: When fault is raised, acc_valid is 0 and sp_out equals the request's stack pointer.
- R9: req_ready is high whenever reset is low. A request accepted at a clock edge produces done=1, and the registered results, right after that edge. done is 0 after any edge with no accepted request. Kind 2'b11 is a no-op: done with no access, no fault and an unchanged pointer.
- R10: During reset, done, acc_valid, fault and req_ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 2 | 00 selector push, 01 selector pop, 10 error-code push, 11 no-op |
| req_op32 | input | 1 | Operand size is 4 bytes (else 2) |
| req_stk32 | input | 1 | Stack segment is 32-bit (else 16-bit) |
| req_wide | input | 1 | Wide legacy mode (else narrow) |
| req_sp | input | 32 | Current stack pointer |
| req_limit | input | 32 | Highest valid offset in the stack segment |
| req_payload | input | 16 | Selector or error-code value to push |
| done | output | 1 | One-cycle result strobe |
| sp_out | output | 32 | Updated stack pointer |
| acc_valid | output | 1 | A memory access is issued this cycle |
| acc_write | output | 1 | Access is a write (else read) |
| acc_addr | output | 32 | Offset of the access slot |
| acc_be | output | 4 | Byte-lane enables, lane 0 at the slot address |
| acc_wdata | output | 32 | Write data, value in lanes 0–1 |
| fault | output | 1 | Segment-limit fault for this request |

## Verification
The bench uses the default parameters: a 32-bit pointer, four byte lanes, a 16-bit value and a 16-bit narrow stack. With these values the 0xFFFC and 0xFFFE pop wraps and the upper-half preservation on a 16-bit segment can be reached directly. The 32-bit pointer lets random pointers land near the 32-bit wrap. Four lanes make the narrow-versus-wide difference visible as 4'b0011 against 4'b1111, and limits placed one to three bytes past the slot start separate the wide faults from the narrow non-faults.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        RK_SEL_PUSH = 2'b00,
        RK_SEL_POP  = 2'b01,
        RK_ERR_PUSH = 2'b10,
        RK_NONE     = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic       is_push;
        logic       is_access;
        logic [2:0] step;
        logic [2:0] nbytes;
    } size_info_t;

    localparam logic [2:0] HALF_BYTES = 3'd2;
    localparam logic [2:0] FULL_BYTES = 3'd4;

    function automatic logic [2:0] op_bytes(input logic op32);
        return op32 ? FULL_BYTES : HALF_BYTES;
    endfunction

endpackage

// File: rtl/stk_size_decode.sv
module stk_size_decode
    import stk_pkg::*;
(
    input  req_kind_e  kind_i,
    input  logic       op32_i,
    input  logic       wide_i,
    output size_info_t info_o
);
    logic [2:0] opb;

    always_comb begin
        opb    = op_bytes(op32_i);
        info_o = '0;
        unique case (kind_i)
            RK_SEL_PUSH, RK_ERR_PUSH: begin
                info_o.is_push   = 1'b1;
                info_o.is_access = 1'b1;
                info_o.step      = opb;
                info_o.nbytes    = wide_i ? opb : HALF_BYTES;
            end
            RK_SEL_POP: begin
                info_o.is_push   = 1'b0;
                info_o.is_access = 1'b1;
                info_o.step      = opb;
                info_o.nbytes    = wide_i ? opb : HALF_BYTES;
            end
            default: info_o = '0;
        endcase
    end
endmodule

// File: rtl/stk_addr_calc.sv
module stk_addr_calc
    import stk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NARROW_W = 16
) (
    input  size_info_t    info_i,
    input  logic          stk32_i,
    input  logic [AW-1:0] sp_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] new_sp_o,
    output logic [AW-1:0] addr_o,
    output logic          fault_o
);
    localparam logic [AW:0] ONE_W = {{AW{1'b0}}, 1'b1};

    logic [AW-1:0] step_w;
    logic [AW-1:0] moved;
    logic [AW-1:0] base;
    logic [AW:0]   last_off;

    assign step_w = {{(AW-3){1'b0}}, info_i.step};
    assign moved  = info_i.is_push ? (sp_i - step_w) : (sp_i + step_w);
    assign base   = info_i.is_push ? moved : sp_i;

    generate
        if (AW > NARROW_W) begin : g_split
            assign new_sp_o = stk32_i ? moved
                                      : {sp_i[AW-1:NARROW_W], moved[NARROW_W-1:0]};
            assign addr_o   = stk32_i ? base
                                      : {{(AW-NARROW_W){1'b0}}, base[NARROW_W-1:0]};
        end else begin : g_flat
            assign new_sp_o = moved;
            assign addr_o   = base;
        end
    endgenerate

    assign last_off = {1'b0, addr_o} + {{(AW-2){1'b0}}, info_i.nbytes} - ONE_W;
    assign fault_o  = info_i.is_access && (last_off > {1'b0, limit_i});
endmodule

// File: rtl/stk_lane_pack.sv
module stk_lane_pack #(
    parameter int LANES = 4,
    parameter int SELW  = 16
) (
    input  logic [2:0]         nbytes_i,
    input  logic [SELW-1:0]    payload_i,
    output logic [LANES-1:0]   be_o,
    output logic [LANES*8-1:0] wdata_o
);
    localparam int DW = LANES * 8;

    logic [31:0] nb_w;
    assign nb_w = {29'b0, nbytes_i};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_o[g] = (nb_w > g);
    end

    assign wdata_o = {{(DW-SELW){1'b0}}, payload_i};
endmodule

// File: rtl/stk_access_gen.sv
module stk_access_gen
    import stk_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LANES    = 4,
    parameter int SELW     = 16,
    parameter int NARROW_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic               req_op32,
    input  logic               req_stk32,
    input  logic               req_wide,
    input  logic [AW-1:0]      req_sp,
    input  logic [AW-1:0]      req_limit,
    input  logic [SELW-1:0]    req_payload,
    output logic               done,
    output logic [AW-1:0]      sp_out,
    output logic               acc_valid,
    output logic               acc_write,
    output logic [AW-1:0]      acc_addr,
    output logic [LANES-1:0]   acc_be,
    output logic [LANES*8-1:0] acc_wdata,
    output logic               fault
);
    localparam int DW = LANES * 8;

    size_info_t       info;
    logic [AW-1:0]    new_sp_c;
    logic [AW-1:0]    addr_c;
    logic             fault_c;
    logic [LANES-1:0] be_c;
    logic [DW-1:0]    wdata_c;
    logic             accept;
    logic             issue;

    stk_size_decode u_dec (
        .kind_i (req_kind_e'(req_kind)),
        .op32_i (req_op32),
        .wide_i (req_wide),
        .info_o (info)
    );

    stk_addr_calc #(.AW(AW), .NARROW_W(NARROW_W)) u_addr (
        .info_i   (info),
        .stk32_i  (req_stk32),
        .sp_i     (req_sp),
        .limit_i  (req_limit),
        .new_sp_o (new_sp_c),
        .addr_o   (addr_c),
        .fault_o  (fault_c)
    );

    stk_lane_pack #(.LANES(LANES), .SELW(SELW)) u_lane (
        .nbytes_i  (info.nbytes),
        .payload_i (req_payload),
        .be_o      (be_c),
        .wdata_o   (wdata_c)
    );

    assign req_ready = ~rst;
    assign accept    = req_valid & req_ready;
    assign issue     = info.is_access & ~fault_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            acc_valid <= 1'b0;
            fault     <= 1'b0;
            acc_write <= 1'b0;
            sp_out    <= '0;
            acc_addr  <= '0;
            acc_be    <= '0;
            acc_wdata <= '0;
        end else begin
            done      <= accept;
            acc_valid <= accept & issue;
            fault     <= accept & fault_c;
            if (accept) begin
                sp_out    <= fault_c ? req_sp : new_sp_c;
                acc_write <= issue & info.is_push;
                acc_addr  <= issue ? addr_c : '0;
                acc_be    <= issue ? be_c : '0;
                acc_wdata <= (issue & info.is_push) ? wdata_c : '0;
            end
        end
    end

    // Handshake timing
    assert_done_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> done);
    assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !done);

    // Fault suppresses access and pointer movement
    assert_fault_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (fault |-> (!acc_valid && sp_out == $past(req_sp))));

    // 16-bit stack keeps the upper pointer half
    assert_stk16_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_stk32) |=>
            (sp_out[AW-1:NARROW_W] == $past(req_sp[AW-1:NARROW_W])));

    // Upper write lanes always zero
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |-> (acc_wdata[DW-1:SELW] == '0));

    // Narrow mode touches two lanes only
    assert_narrow_lanes_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_wide) |=>
            (acc_valid |-> (acc_be == {{(LANES-2){1'b0}}, 2'b11})));
endmodule

// File: tb/tb_stk_access_gen.sv
module tb_stk_access_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic        req_op32 = 1'b0, req_stk32 = 1'b0, req_wide = 1'b0;
    logic [31:0] req_sp = '0, req_limit = '0;
    logic [15:0] req_payload = '0;
    logic        done, acc_valid, acc_write, fault;
    logic [31:0] sp_out, acc_addr, acc_wdata;
    logic [3:0]  acc_be;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    stk_access_gen dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_op32(req_op32), .req_stk32(req_stk32),
        .req_wide(req_wide), .req_sp(req_sp), .req_limit(req_limit),
        .req_payload(req_payload), .done(done), .sp_out(sp_out),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .fault(fault)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] kind, input logic op32, input logic stk32,
                          input logic wide, input logic [31:0] sp, input logic [31:0] lim,
                          input logic [15:0] pay);
        logic [31:0] step, nb, moved, nsp, base, addr, exp_sp;
        logic [32:0] last;
        logic        acc, push, flt;
        string       t_sp, t_be;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_op32 = op32; req_stk32 = stk32;
        req_wide = wide; req_sp = sp; req_limit = lim; req_payload = pay;
        acc  = (kind != 2'b11);
        push = (kind == 2'b00) || (kind == 2'b10);
        step = acc ? (op32 ? 32'd4 : 32'd2) : 32'd0;
        nb   = acc ? (wide ? step : 32'd2) : 32'd0;
        moved = push ? sp - step : sp + step;
        nsp   = stk32 ? moved : {sp[31:16], moved[15:0]};
        base  = push ? moved : sp;
        addr  = stk32 ? base : {16'h0, base[15:0]};
        last  = {1'b0, addr} + {1'b0, nb} - 33'd1;
        flt   = acc && (last > {1'b0, lim});
        exp_sp = flt ? sp : nsp;
        t_sp = !stk32 ? "R6" : (kind == 2'b01 ? "R4" : (kind == 2'b10 ? "R5" : "R1"));
        t_be = !wide ? "R2" : (kind == 2'b10 ? "R5" : "R3");
        @(posedge clk); #1;
        chk("R9", "done", {31'b0, done}, 32'd1);
        chk("R7", "fault", {31'b0, fault}, {31'b0, flt});
        chk(flt ? "R8" : "R9", "acc_valid", {31'b0, acc_valid}, {31'b0, acc && !flt});
        chk(flt ? "R8" : t_sp, "sp_out", sp_out, exp_sp);
        if (acc && !flt) begin
            chk(t_sp, "acc_addr", acc_addr, addr);
            chk(t_be, "acc_be", {28'b0, acc_be}, (nb == 32'd4) ? 32'hF : 32'h3);
            chk(push ? "R1" : "R4", "acc_write", {31'b0, acc_write}, {31'b0, push});
            if (push) chk(t_be, "acc_wdata", acc_wdata, {16'h0, pay});
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9", "done idle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rs, rl;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "done rst", {31'b0, done}, 32'd0);
        chk("R10", "acc_valid rst", {31'b0, acc_valid}, 32'd0);
        chk("R10", "fault rst", {31'b0, fault}, 32'd0);
        chk("R10", "ready rst", {31'b0, req_ready}, 32'd0);
        @(negedge clk); rst = 1'b0;
        #1 chk("R9", "ready", {31'b0, req_ready}, 32'd1);

        // Directed corners
        do_req(2'b00, 1, 1, 0, 32'h0000_1000, 32'hFFFF_FFFF, 16'hBEEF); // R2 narrow push
        do_req(2'b00, 1, 1, 1, 32'h0000_1000, 32'hFFFF_FFFF, 16'hCAFE); // R3 wide push
        do_req(2'b00, 0, 1, 1, 32'h0000_0002, 32'hFFFF_FFFF, 16'h1234); // R1 2-byte
        do_req(2'b01, 1, 0, 0, 32'hABCD_FFFC, 32'h0000_FFFF, 16'h0);    // R6 wrap 4
        do_req(2'b01, 0, 0, 1, 32'h1234_FFFE, 32'h0000_FFFF, 16'h0);    // R6 wrap 2
        do_req(2'b00, 0, 0, 0, 32'h5555_0000, 32'h0000_FFFF, 16'h7777); // R6 push wrap
        do_req(2'b01, 1, 1, 1, 32'h0000_0FFE, 32'h0000_0FFF, 16'h0);    // R7 wide fault
        do_req(2'b01, 1, 1, 0, 32'h0000_0FFE, 32'h0000_0FFF, 16'h0);    // R7 narrow ok
        do_req(2'b00, 1, 1, 1, 32'h0000_1002, 32'h0000_1000, 16'h9999); // R8 fault push
        do_req(2'b10, 1, 1, 0, 32'h0000_0200, 32'hFFFF_FFFF, 16'h00AB); // R5 narrow err
        do_req(2'b10, 1, 1, 1, 32'h0000_0200, 32'hFFFF_FFFF, 16'h00CD); // R5 wide err
        do_req(2'b11, 1, 1, 1, 32'h0000_0300, 32'h0000_0000, 16'h1111); // R9 no-op

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            rs = $urandom;
            if ($urandom_range(0, 3) == 0) rs[15:0] = 16'hFFFC + 16'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0: rl = 32'hFFFF_FFFF;
                1: rl = {16'h0, rs[15:0]} + 32'($urandom_range(0, 3));
                default: rl = rs + 32'($urandom_range(0, 3));
            endcase
            do_req(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   rs, rl, 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule